// File: doc/BRIEF.md
# Multicycle Accumulator Processor Sequencer

This block is a small accumulator processor core. It repeats a fetch, decode and execute loop and moves data through five visible registers: a program counter, an address staging register (MAR), a data staging register (MDR), an instruction register (CIR) and an accumulator. Every memory access goes through MAR and MDR. The core never addresses memory straight from the PC or from an operand field. Each step moves one register per cycle, in a fixed order, so any cycle of a run can be predicted from the program alone.

The core drives one single-port synchronous memory. It has an address, write data, read data, a read strobe and a write strobe. Read data returns one cycle after the strobe. The instruction set has four instructions: load, add, store and halt. The current state and all five registers are brought out as debug outputs, so a bench can follow the register-transfer order cycle by cycle.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, and in the first cycle after it, the state code is 0. The PC equals the parameter `RESET_PC` (default 5). MAR, MDR, CIR and the accumulator are zero, `halted_o` is low and both strobes are low.
- R2: The fetch runs through state codes 0 to 5, one transfer per code. Code 0 copies PC to MAR. Code 1 raises the read strobe with the address equal to MAR. Code 2 captures the read data into MDR, one cycle after the strobe. Code 3 copies MDR to CIR. Code 4 increments the PC by one. Code 5 is decode.
- R3: An instruction word is 8 bits. Bits [7:6] hold the opcode: 00 load, 01 add, 10 store, 11 halt. Bits [5:0] hold the operand address, and all 64 addresses can be reached. Decode looks only at CIR.
- R4: Load runs code 6 (MAR takes the operand), code 7 (read strobe), code 8 (MDR takes the read data) and code 9 (the accumulator takes MDR, replacing its old value). Fetch then resumes at code 0.
- R5: Add follows the same codes 6 to 9 as load. In code 9 the accumulator becomes accumulator + MDR, modulo 256.
- R6: Store runs code 6 (MAR takes the operand), code 10 (MDR takes the accumulator) and code 11. In code 11 the write strobe is high, the address is MAR and the write data is MDR. No read strobe is raised during a store's execute codes.
- R7: Halt enters code 12 and raises `halted_o`. From then on the state, PC, MAR, MDR, CIR and accumulator hold their values, and no strobe is raised until reset.
- R8: The read and write strobes are never high in the same cycle.
- R9: The program at address 5 is load 10, add 12, store 11, halt, with location 10 holding 8 and location 12 holding 4. After it runs, location 11 holds 12.
- R10: Reset taken while halted clears `halted_o` and restarts fetch at `RESET_PC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 6 | Memory address, driven from MAR |
| mem_wdata_o | output | 8 | Memory write data, driven from MDR |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the read strobe |
| mem_rd_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| halted_o | output | 1 | High once a halt instruction has executed |
| dbg_state_o | output | 4 | Current sequencer state code |
| dbg_pc_o | output | 6 | Program counter |
| dbg_mar_o | output | 6 | Address staging register |
| dbg_mdr_o | output | 8 | Data staging register |
| dbg_cir_o | output | 8 | Current instruction register |
| dbg_acc_o | output | 8 | Accumulator |

## Verification
The bench compares the sample program against a per-cycle register trace. A design that captured MDR in the strobe cycle, or that incremented the PC before CIR was loaded, would miss the trace by one cycle. Sums that cross 255 check that add wraps and does not saturate. A second load after an add checks that load replaces the accumulator and does not add to it. A store to operand 63 checks that the full operand field reaches MAR. A program that halts at once, and a long wait after a halt, check that no strobe leaks and no register moves while halted. A reset during the halt checks that the sticky halt is cleared.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OPC_W = 2;

  typedef enum logic [3:0] {
    S_F_ADDR   = 4'd0,
    S_F_RD     = 4'd1,
    S_F_CAP    = 4'd2,
    S_F_IR     = 4'd3,
    S_PC_INC   = 4'd4,
    S_DECODE   = 4'd5,
    S_EX_ADDR  = 4'd6,
    S_EX_RD    = 4'd7,
    S_EX_CAP   = 4'd8,
    S_EX_ALU   = 4'd9,
    S_EX_STAGE = 4'd10,
    S_EX_WR    = 4'd11,
    S_HALT     = 4'd12
  } state_e;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 2'b00,
    OP_ADD   = 2'b01,
    OP_STORE = 2'b10,
    OP_HALT  = 2'b11
  } opc_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_opd;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic cir_from_mdr;
    logic pc_inc;
    logic acc_load;
    logic acc_add;
    logic rd;
    logic we;
  } ctl_t;
endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  opc_e   opc_i,
  output state_e state_o,
  output ctl_t   ctl_o,
  output logic   halted_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_F_ADDR:   state_d = S_F_RD;
      S_F_RD:     state_d = S_F_CAP;
      S_F_CAP:    state_d = S_F_IR;
      S_F_IR:     state_d = S_PC_INC;
      S_PC_INC:   state_d = S_DECODE;
      S_DECODE:   state_d = (opc_i == OP_HALT) ? S_HALT : S_EX_ADDR;
      S_EX_ADDR:  state_d = (opc_i == OP_STORE) ? S_EX_STAGE : S_EX_RD;
      S_EX_RD:    state_d = S_EX_CAP;
      S_EX_CAP:   state_d = S_EX_ALU;
      S_EX_ALU:   state_d = S_F_ADDR;
      S_EX_STAGE: state_d = S_EX_WR;
      S_EX_WR:    state_d = S_F_ADDR;
      S_HALT:     state_d = S_HALT;
      default:    state_d = S_F_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_F_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctl_o              = '0;
    ctl_o.mar_from_pc  = (state_q == S_F_ADDR);
    ctl_o.mar_from_opd = (state_q == S_EX_ADDR);
    ctl_o.mdr_from_mem = (state_q == S_F_CAP) || (state_q == S_EX_CAP);
    ctl_o.mdr_from_acc = (state_q == S_EX_STAGE);
    ctl_o.cir_from_mdr = (state_q == S_F_IR);
    ctl_o.pc_inc       = (state_q == S_PC_INC);
    ctl_o.acc_load     = (state_q == S_EX_ALU) && (opc_i == OP_LOAD);
    ctl_o.acc_add      = (state_q == S_EX_ALU) && (opc_i == OP_ADD);
    ctl_o.rd           = (state_q == S_F_RD) || (state_q == S_EX_RD);
    ctl_o.we           = (state_q == S_EX_WR);
  end

  assign state_o  = state_q;
  assign halted_o = (state_q == S_HALT);

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_o.rd && ctl_o.we)); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HALT) |=> (state_q == S_HALT)); // R7
  AST_RD_THEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.rd |=> ctl_o.mdr_from_mem); // R2
endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int RESET_PC = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [DATA_W-1:0] cir_o,
  output logic [DATA_W-1:0] acc_o
);
  localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, cir_q, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= PC_RST;
      mar_q <= '0;
      mdr_q <= '0;
      cir_q <= '0;
      acc_q <= '0;
    end else begin
      if (ctl_i.pc_inc)            pc_q  <= pc_q + 1'b1;
      if (ctl_i.mar_from_pc)       mar_q <= pc_q;
      else if (ctl_i.mar_from_opd) mar_q <= cir_q[ADDR_W-1:0];
      if (ctl_i.mdr_from_mem)      mdr_q <= rdata_i;
      else if (ctl_i.mdr_from_acc) mdr_q <= acc_q;
      if (ctl_i.cir_from_mdr)      cir_q <= mdr_q;
      if (ctl_i.acc_load)          acc_q <= mdr_q;
      else if (ctl_i.acc_add)      acc_q <= acc_q + mdr_q; // wraps modulo 2^DATA_W
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign cir_o = cir_q;
  assign acc_o = acc_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + 1'b1)); // R2
  AST_CIR_FROM_MDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cir_q != $past(cir_q)) |-> (cir_q == $past(mdr_q))); // R2
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int RESET_PC = 5,
  localparam int DATA_W  = OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic              halted_o,
  output logic [3:0]        dbg_state_o,
  output logic [ADDR_W-1:0] dbg_pc_o,
  output logic [ADDR_W-1:0] dbg_mar_o,
  output logic [DATA_W-1:0] dbg_mdr_o,
  output logic [DATA_W-1:0] dbg_cir_o,
  output logic [DATA_W-1:0] dbg_acc_o
);
  state_e            state;
  ctl_t              ctl;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, cir, acc;
  opc_e              opc;

  assign opc = opc_e'(cir[DATA_W-1 -: OPC_W]);

  acc_cpu_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opc_i    (opc),
    .state_o  (state),
    .ctl_o    (ctl),
    .halted_o (halted_o)
  );

  acc_cpu_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl),
    .rdata_i (mem_rdata_i),
    .pc_o    (pc),
    .mar_o   (mar),
    .mdr_o   (mdr),
    .cir_o   (cir),
    .acc_o   (acc)
  );

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mdr;
  assign mem_rd_o    = ctl.rd;
  assign mem_we_o    = ctl.we;
  assign dbg_state_o = state;
  assign dbg_pc_o    = pc;
  assign dbg_mar_o   = mar;
  assign dbg_mdr_o   = mdr;
  assign dbg_cir_o   = cir;
  assign dbg_acc_o   = acc;

  AST_ACC_ONLY_IN_ALU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc != $past(acc)) |-> ($past(state) == S_EX_ALU)); // R4
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> ($stable(pc) && $stable(acc) && $stable(mdr)
                                       && !mem_rd_o && !mem_we_o)); // R7
  AST_WE_FROM_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> ($past(state) == S_EX_STAGE)); // R6
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 8;

  typedef struct packed {
    logic [7:0] cyc;
    logic [3:0] st;
    logic [7:0] pc, mar, mdr, cir, acc;
    logic       rd, we;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'd0,  4'd0,  8'd5, 8'd0,  8'h00, 8'h00, 8'd0,  1'b0, 1'b0},
    '{8'd1,  4'd1,  8'd5, 8'd5,  8'h00, 8'h00, 8'd0,  1'b1, 1'b0},
    '{8'd3,  4'd3,  8'd5, 8'd5,  8'h0A, 8'h00, 8'd0,  1'b0, 1'b0},
    '{8'd4,  4'd4,  8'd5, 8'd5,  8'h0A, 8'h0A, 8'd0,  1'b0, 1'b0},
    '{8'd5,  4'd5,  8'd6, 8'd5,  8'h0A, 8'h0A, 8'd0,  1'b0, 1'b0},
    '{8'd7,  4'd7,  8'd6, 8'd10, 8'h0A, 8'h0A, 8'd0,  1'b1, 1'b0},
    '{8'd9,  4'd9,  8'd6, 8'd10, 8'd8,  8'h0A, 8'd0,  1'b0, 1'b0},
    '{8'd10, 4'd0,  8'd6, 8'd10, 8'd8,  8'h0A, 8'd8,  1'b0, 1'b0},
    '{8'd19, 4'd9,  8'd7, 8'd12, 8'd4,  8'h4C, 8'd8,  1'b0, 1'b0},
    '{8'd20, 4'd0,  8'd7, 8'd12, 8'd4,  8'h4C, 8'd12, 1'b0, 1'b0},
    '{8'd27, 4'd10, 8'd8, 8'd11, 8'h8B, 8'h8B, 8'd12, 1'b0, 1'b0},
    '{8'd28, 4'd11, 8'd8, 8'd11, 8'd12, 8'h8B, 8'd12, 1'b0, 1'b1},
    '{8'd35, 4'd12, 8'd9, 8'd8,  8'hC0, 8'hC0, 8'd12, 1'b0, 1'b0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_rd, mem_we, halted;
  logic [3:0]    st;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, cir, acc;

  logic [DW-1:0] mem [64];
  int            cyc;
  int            n_wr;
  int            checks = 0;
  int            errors = 0;
  bit            both_seen = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  acc_cpu u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_rd_o    (mem_rd),
    .mem_we_o    (mem_we),
    .halted_o    (halted),
    .dbg_state_o (st),
    .dbg_pc_o    (pc),
    .dbg_mar_o   (mar),
    .dbg_mdr_o   (mdr),
    .dbg_cir_o   (cir),
    .dbg_acc_o   (acc)
  );

  // synchronous single-port RAM, one cycle read latency
  always @(posedge clk_i) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      n_wr = n_wr + 1;
    end
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  always @(negedge clk_i) if (rst_ni && mem_rd && mem_we) both_seen = 1'b1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] s);
    if (s <= 4'd5)       return "R2";
    else if (s <= 4'd9)  return "R4_R5";
    else if (s <= 4'd11) return "R6";
    else                 return "R7";
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    n_wr = 0;
  endtask

  task automatic start();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run_to_halt(input string req);
    int guard = 0;
    while (!halted && guard < 400) begin
      @(negedge clk_i);
      guard++;
    end
    chk(req, "halted reached", int'(halted), 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // demonstration program
    clear_mem();
    mem[5]  = 8'h0A;  // load 10
    mem[6]  = 8'h4C;  // add 12
    mem[7]  = 8'h8B;  // store 11
    mem[8]  = 8'hC0;  // halt
    mem[10] = 8'd8;
    mem[12] = 8'd4;
    @(negedge clk_i);
    // R1 reset state while held
    chk("R1", "state", int'(st), 0);
    chk("R1", "pc", int'(pc), 5);
    chk("R1", "mar|mdr|cir|acc", int'(mar) + int'(mdr) + int'(cir) + int'(acc), 0);
    chk("R1", "halted|rd|we", int'(halted) + int'(mem_rd) + int'(mem_we), 0);
    start();

    for (int v = 0; v < NV; v++) begin
      while (cyc < int'(VEC[v].cyc)) @(negedge clk_i);
      chk(req_of(VEC[v].st), $sformatf("state@%0d", cyc), int'(st), int'(VEC[v].st));
      chk(req_of(VEC[v].st), $sformatf("pc@%0d", cyc), int'(pc), int'(VEC[v].pc));
      chk(req_of(VEC[v].st), $sformatf("mar@%0d", cyc), int'(mar), int'(VEC[v].mar));
      chk(req_of(VEC[v].st), $sformatf("mdr@%0d", cyc), int'(mdr), int'(VEC[v].mdr));
      chk(req_of(VEC[v].st), $sformatf("cir@%0d", cyc), int'(cir), int'(VEC[v].cir));
      chk(req_of(VEC[v].st), $sformatf("acc@%0d", cyc), int'(acc), int'(VEC[v].acc));
      chk(req_of(VEC[v].st), $sformatf("rd@%0d", cyc), int'(mem_rd), int'(VEC[v].rd));
      chk(req_of(VEC[v].st), $sformatf("we@%0d", cyc), int'(mem_we), int'(VEC[v].we));
      if (VEC[v].we) begin
        chk("R6", "write addr", int'(mem_addr), 11);
        chk("R6", "write data", int'(mem_wdata), 12);
      end
    end
    chk("R9", "mem[11]", int'(mem[11]), 12);
    chk("R7", "halted_o", int'(halted), 1);

    // R7: frozen while halted, no strobes
    begin
      int strobes = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk_i);
        strobes += int'(mem_rd) + int'(mem_we);
      end
      chk("R7", "strobes while halted", strobes, 0);
      chk("R7", "state held", int'(st), 12);
      chk("R7", "pc held", int'(pc), 9);
      chk("R7", "acc held", int'(acc), 12);
    end

    // R10: reset clears halt
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R10", "halted after reset", int'(halted), 0);
    chk("R10", "state after reset", int'(st), 0);
    chk("R10", "pc after reset", int'(pc), 5);

    // R5 wraparound, R4 load replaces, R3 top operand address
    clear_mem();
    mem[5]  = 8'h14;  // load 20
    mem[6]  = 8'h55;  // add 21
    mem[7]  = 8'h96;  // store 22
    mem[8]  = 8'h17;  // load 23
    mem[9]  = 8'hBF;  // store 63
    mem[10] = 8'hC0;  // halt
    mem[20] = 8'd200;
    mem[21] = 8'd100;
    mem[23] = 8'd9;
    start();
    run_to_halt("R3");
    chk("R5", "200+100 wraps", int'(mem[22]), 44);
    chk("R4", "load replaces acc", int'(acc), 9);
    chk("R3", "store to operand 63", int'(mem[63]), 9);
    chk("R3", "pc after six instrs", int'(pc), 11);
    chk("R6", "write count", n_wr, 2);

    // R7: halt as first instruction
    clear_mem();
    mem[5] = 8'hFF;   // halt, operand ignored
    mem[63] = 8'd77;
    start();
    run_to_halt("R7");
    chk("R7", "halt-first cycle", cyc, 6);
    chk("R7", "halt-first pc", int'(pc), 6);
    chk("R7", "halt-first acc", int'(acc), 0);
    chk("R7", "halt-first mar", int'(mar), 5);
    chk("R7", "halt-first no write", n_wr, 0);

    chk("R8", "rd and we together", int'(both_seen), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule